// File: doc/BRIEF.md
# Memory-Side Atomic Fetch-and-Add Serializer

This block sits at the memory end of the hierarchy and takes fetch-and-add requests that found no writeable cached copy on their way out. Each request carries a word address, an addend and a requester tag. Requests queue in a FIFO and are served one at a time, strictly in the order they were accepted.

For the request at the head of the queue, the block raises a system-wide invalidate carrying the word address. It holds that invalidate until every cache has acknowledged once. A cache that held the line modified acknowledges with its dirty data, and that data is merged into the local word array first. Only then is the word read, the addend applied, and the sum stored. The old value is returned together with the requester tag. Memory device timing is not modelled: the storage is a flat register array that clears on reset.

Top module: `atomic_serializer`

## Requirements
- R1: The request queue holds up to DEPTH requests, counting the one in service. `req_ready` is low exactly while DEPTH requests are held. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. A request offered while `req_ready` is low is dropped.
- R2: Responses come out in the same order in which the requests were accepted.
- R3: While a request is in service, `inv_valid` stays high and `inv_addr` carries that request's address, until all NC caches have acknowledged. `inv_valid` is low at every other time.
- R4: Each cache's acknowledgement counts once per invalidate. A repeated acknowledgement from the same cache does not count again. Acknowledgements that arrive while `inv_valid` is low are ignored.
- R5: An acknowledgement with `ack_dirty[i]` set writes slice i of `ack_data` (bits i*DW and up, DW wide) into the addressed word before the word is read. If several caches report dirty data, the lowest-numbered one wins.
- R6: The word is read after the merge, and the addend is added modulo 2^DW. The sum is written back, and `rsp_old` returns the value from before the add.
- R7: `rsp_valid` is high for exactly one cycle per request, with `rsp_id` equal to that request's tag. No response appears while the invalidate is still outstanding.
- R8: After reset, every memory word is zero, the queue is empty, `req_ready` is high, and `inv_valid` and `rsp_valid` are low.
- R9: Counting from the clock edge that captures the last missing acknowledgement, `rsp_valid` rises after the fifth following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_addr | input | AW | Word address of the request |
| req_operand | input | DW | Addend |
| req_id | input | IDW | Requester tag |
| inv_valid | output | 1 | Invalidate broadcast active |
| inv_addr | output | AW | Address being invalidated |
| ack_valid | input | NC | Per-cache acknowledgement |
| ack_dirty | input | NC | Per-cache flag: acknowledgement carries modified data |
| ack_data | input | NC*DW | Per-cache writeback data, slice i for cache i |
| rsp_valid | output | 1 | Response strobe |
| rsp_id | output | IDW | Tag of the request being answered |
| rsp_old | output | DW | Word value before the add |

## Verification
A vector table applies additions at several addresses: repeated additions at one address, an addition that wraps past 2^DW, and requests where one of three different caches returns dirty data. A response that matches the expected value in every case shows that the merge, the read, the add and the write happen in the right order. A burst that fills the queue, followed by an extra request that must be dropped, separates arrival-order service from any other order and proves the full limit. Three further patterns check how acknowledgements are handled: stray acknowledgements while idle, repeated acknowledgements from one cache, and two caches both reporting dirty data. These show that each cache counts once per invalidate, that acknowledgements outside an invalidate are ignored, and that the lowest-numbered dirty cache wins.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SNOOP = 3'd1,
    ST_WBACK = 3'd2,
    ST_READ  = 3'd3,
    ST_ADD   = 3'd4,
    ST_WRITE = 3'd5,
    ST_RESP  = 3'd6
  } serial_state_t;
endpackage

// File: rtl/atom_fifo.sv
module atom_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]    slot_q [DEPTH];
  logic [PTRW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q[g] <= '0;
      else if (push && wr_ptr_q == PTRW'(g))       slot_q[g] <= din;
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/snoop_collect.sv
module snoop_collect #(
  parameter int NC = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [NC-1:0]   ack_valid,
  input  logic [NC-1:0]   ack_dirty,
  input  logic [NC*DW-1:0] ack_data,
  output logic            all_acked,
  output logic            wb_valid,
  output logic [DW-1:0]   wb_data
);
  logic [NC-1:0] seen_q;
  logic [NC-1:0] dirty_q;
  logic [DW-1:0] data_q [NC];

  for (genvar g = 0; g < NC; g++) begin : g_cache
    logic take;
    assign take = en && ack_valid[g] && !seen_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[g]  <= 1'b0;
        dirty_q[g] <= 1'b0;
        data_q[g]  <= '0;
      end else if (clr) begin
        seen_q[g]  <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (take) begin
        seen_q[g]  <= 1'b1;
        dirty_q[g] <= ack_dirty[g];
        data_q[g]  <= ack_data[g*DW +: DW];
      end
    end
  end

  assign all_acked = &seen_q;

  always_comb begin
    wb_valid = 1'b0;
    wb_data  = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (dirty_q[i]) begin
        wb_valid = 1'b1;
        wb_data  = data_q[i];
      end
    end
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cell_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cell_q[g] <= '0;
      else if (we && addr == AW'(g))       cell_q[g] <= wdata;
    end
  end

  assign rdata = cell_q[addr];
endmodule

// File: rtl/atomic_serializer.sv
module atomic_serializer
  import atom_pkg::*;
#(
  parameter int NC    = 4,
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int IDW   = 4,
  parameter int DEPTH = 4,
  localparam int PW   = IDW + AW + DW,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_operand,
  input  logic [IDW-1:0]   req_id,
  output logic             inv_valid,
  output logic [AW-1:0]    inv_addr,
  input  logic [NC-1:0]    ack_valid,
  input  logic [NC-1:0]    ack_dirty,
  input  logic [NC*DW-1:0] ack_data,
  output logic             rsp_valid,
  output logic [IDW-1:0]   rsp_id,
  output logic [DW-1:0]    rsp_old
);
  serial_state_t state_q, state_d;
  logic [PW-1:0]   head;
  logic [CNTW-1:0] fifo_cnt;
  logic            fifo_push, fifo_pop, fifo_empty;
  logic [AW-1:0]   head_addr;
  logic [DW-1:0]   head_op;
  logic [IDW-1:0]  head_id;
  logic            all_acked, wb_valid;
  logic [DW-1:0]   wb_data;
  logic            mem_we;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic [DW-1:0]   old_q, sum_q;
  logic            old_en, sum_en;

  assign req_ready  = (fifo_cnt != CNTW'(DEPTH));
  assign fifo_push  = req_valid && req_ready;
  assign fifo_pop   = (state_q == ST_RESP);
  assign fifo_empty = (fifo_cnt == '0);
  assign {head_id, head_addr, head_op} = head;

  atom_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   ({req_id, req_addr, req_operand}),
    .pop   (fifo_pop),
    .head  (head),
    .count (fifo_cnt)
  );

  snoop_collect #(.NC(NC), .DW(DW)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state_q == ST_SNOOP),
    .clr       (state_q == ST_RESP),
    .ack_valid (ack_valid),
    .ack_dirty (ack_dirty),
    .ack_data  (ack_data),
    .all_acked (all_acked),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data)
  );

  assign mem_we    = (state_q == ST_WBACK && wb_valid) || (state_q == ST_WRITE);
  assign mem_wdata = (state_q == ST_WBACK) ? wb_data : sum_q;

  word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (head_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (!fifo_empty) state_d = ST_SNOOP;
      ST_SNOOP: if (all_acked)   state_d = ST_WBACK;
      ST_WBACK: state_d = ST_READ;
      ST_READ:  state_d = ST_ADD;
      ST_ADD:   state_d = ST_WRITE;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign old_en = (state_q == ST_READ);
  assign sum_en = (state_q == ST_ADD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      sum_q <= '0;
    end else begin
      if (old_en) old_q <= mem_rdata;
      if (sum_en) sum_q <= old_q + head_op;
    end
  end

  assign inv_valid = (state_q == ST_SNOOP);
  assign inv_addr  = head_addr;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_id    = head_id;
  assign rsp_old   = old_q;
endmodule

// File: rtl/atomic_serializer_chk.sv
module atomic_serializer_chk
  import atom_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inv_valid,
  input logic [AW-1:0]   inv_addr,
  input logic            rsp_valid,
  input logic            all_acked,
  input logic [CNTW-1:0] fifo_cnt,
  input serial_state_t   state
);
  // R1: occupancy never exceeds the configured depth
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNTW'(DEPTH));

  // R3: invalidate held until every cache has acknowledged
  p_inv_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !all_acked) |=> inv_valid);

  // R3: address steady while the invalidate is up
  p_inv_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !all_acked) |=> $stable(inv_addr));

  // R7: no response while invalidate outstanding
  p_no_rsp_in_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !rsp_valid);

  // R7: response strobe is a single cycle
  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6: the store of the sum directly follows the add step
  p_write_after_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD) |=> (state == ST_WRITE));
endmodule

bind atomic_serializer atomic_serializer_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inv_valid (inv_valid),
  .inv_addr  (inv_addr),
  .rsp_valid (rsp_valid),
  .all_acked (all_acked),
  .fifo_cnt  (fifo_cnt),
  .state     (state_q)
);

// File: tb/sim_atomic_serializer.sv
module sim_atomic_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, DW = 16, AW = 4, IDW = 4, DEPTH = 4;
  localparam int NV = 8;
  // vector: addr(4) operand(16) id(4) dirty cache (4, F = none) writeback data(16)
  localparam logic [43:0] VEC [NV] = '{
    {4'h3, 16'h0005, 4'h1, 4'hF, 16'h0000},
    {4'h3, 16'h0007, 4'h2, 4'hF, 16'h0000},
    {4'h3, 16'h0001, 4'h3, 4'h2, 16'h0100},
    {4'h9, 16'hFFFF, 4'h4, 4'hF, 16'h0000},
    {4'h9, 16'h0002, 4'h5, 4'hF, 16'h0000},
    {4'h0, 16'h0010, 4'h6, 4'h0, 16'h1234},
    {4'hF, 16'h0003, 4'h7, 4'h3, 16'hABCD},
    {4'h0, 16'h0001, 4'h8, 4'hF, 16'h0000}
  };

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_operand;
  logic [IDW-1:0] req_id;
  logic inv_valid;
  logic [AW-1:0] inv_addr;
  logic [NC-1:0] ack_valid, ack_dirty;
  logic [NC*DW-1:0] ack_data;
  logic rsp_valid;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_old;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [1 << AW];

  atomic_serializer #(.NC(NC), .DW(DW), .AW(AW), .IDW(IDW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_operand(req_operand), .req_id(req_id),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .ack_valid(ack_valid),
    .ack_dirty(ack_dirty), .ack_data(ack_data), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_old(rsp_old));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] op, input logic [IDW-1:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_operand = op; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Serve one invalidate: caches ack one per cycle, then response timing and data checked.
  task automatic serve(input logic [AW-1:0] a, input logic [DW-1:0] op, input logic [IDW-1:0] id,
                       input logic [NC-1:0] dmask, input logic [NC*DW-1:0] wdata);
    logic [DW-1:0] exp_old;
    while (!inv_valid) @(negedge clk);
    chk("R3 inv_addr", 32'(inv_addr), 32'(a));
    for (int i = 0; i < NC; i++) begin
      ack_valid = NC'(1) << i;
      ack_dirty = dmask & (NC'(1) << i);
      ack_data  = wdata;
      @(negedge clk);
      if (i < NC - 1) begin
        chk("R3 inv held", 32'(inv_valid), 32'd1);
        chk("R7 no early rsp", 32'(rsp_valid), 32'd0);
      end
    end
    ack_valid = '0; ack_dirty = '0;
    for (int i = NC - 1; i >= 0; i--)
      if (dmask[i]) model[a] = wdata[i*DW +: DW];
    exp_old  = model[a];
    model[a] = model[a] + op;
    repeat (4) @(negedge clk);
    chk("R9 rsp not yet", 32'(rsp_valid), 32'd0);
    chk("R3 inv dropped", 32'(inv_valid), 32'd0);
    @(negedge clk);
    chk("R9 rsp on time", 32'(rsp_valid), 32'd1);
    chk("R2 R7 rsp_id", 32'(rsp_id), 32'(id));
    chk("R5 R6 rsp_old", 32'(rsp_old), 32'(exp_old));
    @(negedge clk);
    chk("R7 single cycle", 32'(rsp_valid), 32'd0);
  endtask

  function automatic logic [NC*DW-1:0] place(input int c, input logic [DW-1:0] d);
    logic [NC*DW-1:0] v = '0;
    v[c*DW +: DW] = d;
    return v;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req_valid = 0; req_addr = '0; req_operand = '0; req_id = '0;
    ack_valid = '0; ack_dirty = '0; ack_data = '0;
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 ready", 32'(req_ready), 32'd1);
    chk("R8 inv low", 32'(inv_valid), 32'd0);
    chk("R8 rsp low", 32'(rsp_valid), 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      logic [NC-1:0] dm;
      e = VEC[v];
      dm = (e[19:16] == 4'hF) ? '0 : NC'(1) << e[19:16];
      push(e[43:40], e[39:24], e[23:20]);
      serve(e[43:40], e[39:24], e[23:20], dm,
            (e[19:16] == 4'hF) ? '0 : place(int'(e[19:16]), e[15:0]));
    end

    // R1 R2: fill the queue, drop one extra, serve in arrival order
    push(4'h1, 16'h0011, 4'h9);
    push(4'h2, 16'h0022, 4'hA);
    push(4'h3, 16'h0033, 4'hB);
    push(4'h4, 16'h0044, 4'hC);
    chk("R1 ready low when full", 32'(req_ready), 32'd0);
    push(4'h5, 16'h0055, 4'hD);
    serve(4'h1, 16'h0011, 4'h9, '0, '0);
    serve(4'h2, 16'h0022, 4'hA, '0, '0);
    serve(4'h3, 16'h0033, 4'hB, '0, '0);
    serve(4'h4, 16'h0044, 4'hC, '0, '0);
    repeat (8) @(negedge clk);
    chk("R1 dropped request not served", 32'(inv_valid), 32'd0);
    chk("R1 ready back", 32'(req_ready), 32'd1);

    // R4: stray acknowledgements while idle are ignored
    ack_valid = '1; ack_dirty = '1; ack_data = '1;
    @(negedge clk);
    ack_valid = '0; ack_dirty = '0; ack_data = '0;
    push(4'h5, 16'h0001, 4'h2);
    serve(4'h5, 16'h0001, 4'h2, '0, '0);

    // R4: repeated ack from one cache does not complete the invalidate
    push(4'h6, 16'h0002, 4'h3);
    while (!inv_valid) @(negedge clk);
    ack_valid = 4'b0001;
    repeat (3) @(negedge clk);
    ack_valid = '0;
    @(negedge clk);
    chk("R4 dup ack ignored", 32'(inv_valid), 32'd1);
    serve(4'h6, 16'h0002, 4'h3, '0, '0);

    // R5: two dirty caches, lowest index wins
    push(4'h7, 16'h0004, 4'h4);
    serve(4'h7, 16'h0004, 4'h4, 4'b0110, place(1, 16'h0AAA) | place(2, 16'h0BBB));

    finish_run();
  end
endmodule